// File: doc/BRIEF.md
# Serial Command Front End for a Quad 10-Bit DAC

This block is the digital front end of a four-channel, 10-bit digital-to-analog converter. A host writes 16-bit command words over a three-wire serial port made of an active-low chip select, a serial clock and a data line. Each word carries a channel address, a two-bit operation code, a 10-bit data value and two sub-bits that must be zero. The word takes effect when chip select returns high. Depending on the operation, it loads a channel's input register, moves input registers into the DAC registers that drive the converter codes, or enters or leaves software shutdown.

Every bit shifted in also leaves the block on a serial data-out pin, 16 clocks later. The pin therefore presents the previous word while a new one arrives, so several devices can be chained by wiring each data-out to the next data-in. A static select picks whether data-out moves on the rising or the falling serial clock edge.

An active-low lockout input blocks software shutdown while it is low. Driving it low also ends a shutdown at once, with no serial activity, and the converter codes held before shutdown reappear. All serial pins are oversampled by the system clock through two-stage synchronizers. Every output is registered.

Top module: `sdac_cmd_if`

## Requirements
- R1: After synchronous reset, every DAC code reads 0, `shutdown` is 0 and `dout` is 0.
- R2: A word is shifted in MSB first as address[15:14], operation[13:12], data[11:2], sub-bits[1:0]. Operation 00 loads only the addressed input register, and the DAC codes do not change.
- R3: Operation 10 loads the addressed channel's input register and DAC register with the data, and its code output shows the new value.
- R4: Operation 01 loads the addressed input register, then copies all four input registers, including the new value, into the DAC registers.
- R5: Operation 11 with data bit 9 clear copies every input register into its DAC register and leaves shutdown. The address is ignored.
- R6: Operation 11 with data bit 9 set enters shutdown while `pd_lock_n` is high. `shutdown` reads 1 and all codes read 0, and the DAC register contents are kept.
- R7: While `pd_lock_n` is low, a shutdown command has no effect: `shutdown` stays 0 and the codes stay visible.
- R8: Pulling `pd_lock_n` low during shutdown ends the shutdown without any serial clock or chip-select activity, and the codes from before shutdown reappear.
- R9: A word with nonzero sub-bits changes no register, but it is still forwarded on `dout`.
- R10: A frame is executed only when the number of serial clocks between chip-select fall and rise is a nonzero multiple of 16. In that case the last 16 bits received are executed. Any other count changes no register.
- R11: `dout` presents the bits received 16 clocks earlier, starting with the oldest bit when chip select falls. With `dout_rise_sel` = 1, `dout` advances on the serial clock rising edge.
- R12: With `dout_rise_sel` = 0, `dout` advances on the serial clock falling edge and holds across the rising edge.
- R13: A complete 16-bit frame has no effect on the registers until chip select rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial chip select, active low; its rising edge executes the frame |
| sclk | input | 1 | Serial clock; data-in is sampled on its rising edge |
| din | input | 1 | Serial data in, MSB first |
| pd_lock_n | input | 1 | Shutdown lockout and wake input, active low |
| dout_rise_sel | input | 1 | 1: data-out moves on the sclk rising edge; 0: on the falling edge |
| dout | output | 1 | Serial data out, delayed by 16 serial clocks |
| dac_code | output | 40 | Four 10-bit codes, channel n in bits [10n+9:10n] |
| shutdown | output | 1 | High while in software shutdown |

## Verification
The hardest state to reach from the ports is a wake-up caused by the lockout pin alone, with DAC contents that differ from the input registers. The bench gets there by writing distinct codes to each channel, loading different values into the input registers only, entering shutdown by command, and then dropping the lockout pin with chip select idle. A restore from the input registers would show up as a mismatch. The delayed data-out stream is compared on both clock edges of every bit against a bench-side 16-bit history, in both edge modes. This history also covers frames of 5, 15, 17 and 32 clocks.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

  localparam int OP_W  = 2;
  localparam int SUB_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_LOAD_IN    = 2'b00,
    OP_LOAD_SWEEP = 2'b01,
    OP_LOAD_PASS  = 2'b10,
    OP_SPECIAL    = 2'b11
  } op_e;

  function automatic int frame_bits(input int addr_w, input int data_w);
    return addr_w + OP_W + data_w + SUB_W;
  endfunction

endpackage

// File: rtl/sdac_insync.sv
module sdac_insync #(
  parameter int          N       = 4,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw,
  output logic [N-1:0] lvl
);

  for (genvar g = 0; g < N; g++) begin : g_bit
    logic meta_q;
    logic safe_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        meta_q <= RST_VAL[g];
        safe_q <= RST_VAL[g];
      end else begin
        meta_q <= raw[g];
        safe_q <= meta_q;
      end
    end
    assign lvl[g] = safe_q;
  end

endmodule

// File: rtl/sdac_frame.sv
module sdac_frame #(
  parameter int PKT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_lvl,
  input  logic             sclk_lvl,
  input  logic             din_lvl,
  input  logic             out_on_rise,
  output logic             dout,
  output logic [PKT_W-1:0] pkt,
  output logic             pkt_stb
);

  localparam int CNT_W = $clog2(PKT_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PKT_W - 1);

  logic             cs_d, sclk_d;
  logic             cs_rise, cs_fall, sclk_rise, sclk_fall;
  logic [PKT_W-1:0] sr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full_q;
  logic             dout_q;
  logic             stb_q;

  assign cs_rise   =  cs_lvl & ~cs_d;
  assign cs_fall   = ~cs_lvl &  cs_d;
  assign sclk_rise =  sclk_lvl & ~sclk_d;
  assign sclk_fall = ~sclk_lvl &  sclk_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
      sr_q   <= '0;
      cnt_q  <= '0;
      full_q <= 1'b0;
      dout_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      cs_d   <= cs_lvl;
      sclk_d <= sclk_lvl;
      stb_q  <= 1'b0;
      if (cs_fall) begin
        cnt_q  <= '0;
        full_q <= 1'b0;
        dout_q <= sr_q[PKT_W-1];
      end else if (cs_rise) begin
        stb_q <= full_q && (cnt_q == '0);
      end else if (!cs_lvl) begin
        if (sclk_rise) begin
          sr_q <= {sr_q[PKT_W-2:0], din_lvl};
          if (cnt_q == LAST) begin
            cnt_q  <= '0;
            full_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
          if (out_on_rise) dout_q <= sr_q[PKT_W-2];
        end else if (sclk_fall && !out_on_rise) begin
          dout_q <= sr_q[PKT_W-1];
        end
      end
    end
  end

  assign dout    = dout_q;
  assign pkt     = sr_q;
  assign pkt_stb = stb_q;

  // R13: a frame is handed on only right after chip select returns high
  p_exec_at_cs_rise_r13: assert property (@(posedge clk) disable iff (rst)
    pkt_stb |-> (cs_lvl && $past(cs_rise)));

  // R11: data-out holds while chip select stays high
  p_dout_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (cs_lvl && $past(cs_lvl)) |-> $stable(dout_q));

  // R11: in rising-edge mode a falling edge leaves data-out alone
  p_rise_mode_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (out_on_rise && sclk_fall && !cs_fall) |=> $stable(dout_q));

  // R12: in falling-edge mode a rising edge leaves data-out alone
  p_fall_mode_hold_r12: assert property (@(posedge clk) disable iff (rst)
    (!out_on_rise && sclk_rise && !cs_fall && !cs_rise) |=> $stable(dout_q));

endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
  import sdac_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int ADDR_W = 2,
  parameter int PKT_W  = frame_bits(ADDR_W, DATA_W)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         stb,
  input  logic [PKT_W-1:0]             pkt,
  input  logic                         lock_n,
  output logic [(1<<ADDR_W)*DATA_W-1:0] code_o,
  output logic                         off_o
);

  localparam int NCH    = 1 << ADDR_W;
  localparam int OP_LSB = PKT_W - ADDR_W - OP_W;

  logic [ADDR_W-1:0]           addr;
  op_e                         op;
  logic [DATA_W-1:0]           data;
  logic [SUB_W-1:0]            sub;
  logic                        go;

  logic [NCH-1:0][DATA_W-1:0]  in_q;
  logic [NCH-1:0][DATA_W-1:0]  dac_q;
  logic [NCH-1:0][DATA_W-1:0]  code_q;
  logic                        off_q;
  logic                        off_oq;

  assign addr = pkt[PKT_W-1 -: ADDR_W];
  assign op   = op_e'(pkt[OP_LSB +: OP_W]);
  assign data = pkt[SUB_W +: DATA_W];
  assign sub  = pkt[SUB_W-1:0];
  assign go   = stb && (sub == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= '0;
      dac_q <= '0;
      off_q <= 1'b0;
    end else begin
      if (go) begin
        unique case (op)
          OP_LOAD_IN: begin
            in_q[addr] <= data;
          end
          OP_LOAD_SWEEP: begin
            in_q[addr] <= data;
            for (int i = 0; i < NCH; i++) begin
              dac_q[i] <= (ADDR_W'(i) == addr) ? data : in_q[i];
            end
          end
          OP_LOAD_PASS: begin
            in_q[addr]  <= data;
            dac_q[addr] <= data;
          end
          OP_SPECIAL: begin
            if (data[DATA_W-1]) begin
              if (lock_n) off_q <= 1'b1;
            end else begin
              for (int i = 0; i < NCH; i++) dac_q[i] <= in_q[i];
              off_q <= 1'b0;
            end
          end
          default: ;
        endcase
      end
      if (!lock_n) off_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= '0;
      off_oq <= 1'b0;
    end else begin
      for (int i = 0; i < NCH; i++) code_q[i] <= off_q ? '0 : dac_q[i];
      off_oq <= off_q;
    end
  end

  assign code_o = code_q;
  assign off_o  = off_oq;

  // R6: shutdown blanks every code on the same cycle it is reported
  p_blank_when_off_r6: assert property (@(posedge clk) disable iff (rst)
    off_o |-> (code_q == '0));

  // R6: entering shutdown leaves the DAC registers untouched
  p_keep_on_entry_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(off_q) |-> $stable(dac_q));

  // R7: a low lockout pin leaves no shutdown in force on the next cycle
  p_lock_blocks_r7: assert property (@(posedge clk) disable iff (rst)
    !lock_n |=> !off_q);

  // R2: a plain input load never reaches the DAC registers
  p_load_only_r2: assert property (@(posedge clk) disable iff (rst)
    (go && op == OP_LOAD_IN) |=> $stable(dac_q));

  // R3: a pass-through load lands in the addressed DAC register
  p_pass_write_r3: assert property (@(posedge clk) disable iff (rst)
    (go && op == OP_LOAD_PASS) |=> (dac_q[$past(addr)] == $past(data)));

  // R9: nonzero sub-bits leave the register file alone
  p_sub_ignored_r9: assert property (@(posedge clk) disable iff (rst)
    (stb && sub != '0) |=> ($stable(in_q) && $stable(dac_q)));

endmodule

// File: rtl/sdac_cmd_if.sv
module sdac_cmd_if
  import sdac_pkg::*;
#(
  parameter int DATA_W = 10,
  parameter int ADDR_W = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cs_n,
  input  logic                          sclk,
  input  logic                          din,
  input  logic                          pd_lock_n,
  input  logic                          dout_rise_sel,
  output logic                          dout,
  output logic [(1<<ADDR_W)*DATA_W-1:0] dac_code,
  output logic                          shutdown
);

  localparam int PKT_W = frame_bits(ADDR_W, DATA_W);

  // synchronizer lanes: 0 chip select, 1 serial clock, 2 data, 3 lockout
  logic [3:0]       pin_lvl;
  logic [PKT_W-1:0] pkt;
  logic             pkt_stb;

  sdac_insync #(
    .N       (4),
    .RST_VAL (4'b1001)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .raw ({pd_lock_n, din, sclk, cs_n}),
    .lvl (pin_lvl)
  );

  sdac_frame #(
    .PKT_W (PKT_W)
  ) u_frame (
    .clk         (clk),
    .rst         (rst),
    .cs_lvl      (pin_lvl[0]),
    .sclk_lvl    (pin_lvl[1]),
    .din_lvl     (pin_lvl[2]),
    .out_on_rise (dout_rise_sel),
    .dout        (dout),
    .pkt         (pkt),
    .pkt_stb     (pkt_stb)
  );

  sdac_regs #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .PKT_W  (PKT_W)
  ) u_regs (
    .clk    (clk),
    .rst    (rst),
    .stb    (pkt_stb),
    .pkt    (pkt),
    .lock_n (pin_lvl[3]),
    .code_o (dac_code),
    .off_o  (shutdown)
  );

endmodule

// File: tb/sim_sdac_cmd_if.sv
module sim_sdac_cmd_if;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1;
  logic        sclk = 1'b0;
  logic        din = 1'b0;
  logic        pd_lock_n = 1'b1;
  logic        dout_rise_sel = 1'b1;
  logic        dout;
  logic [39:0] dac_code;
  logic        shutdown;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  // bench-side model
  logic [15:0] hist = '0;
  logic        dexp = 1'b0;
  logic [9:0]  in_m  [4];
  logic [9:0]  dac_m [4];
  logic        shut_m = 1'b0;

  always #4 clk = ~clk;

  sdac_cmd_if u0 (
    .clk           (clk),
    .rst           (rst),
    .cs_n          (cs_n),
    .sclk          (sclk),
    .din           (din),
    .pd_lock_n     (pd_lock_n),
    .dout_rise_sel (dout_rise_sel),
    .dout          (dout),
    .dac_code      (dac_code),
    .shutdown      (shutdown)
  );

  task automatic wrap_up();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 190000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: act=%0d cycles exp<190000", cyc);
      wrap_up();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic check_outs(input string tag);
    for (int i = 0; i < 4; i++)
      chk(tag, 32'(dac_code[i*10 +: 10]), shut_m ? 32'd0 : 32'(dac_m[i]));
    chk(tag, 32'(shutdown), 32'(shut_m));
  endtask

  task automatic model_exec(input logic [15:0] w);
    logic [1:0] a, op, sb;
    logic [9:0] d;
    a = w[15:14]; op = w[13:12]; d = w[11:2]; sb = w[1:0];
    if (sb != 2'b00) return;
    case (op)
      2'b00: in_m[a] = d;
      2'b01: begin
        in_m[a] = d;
        for (int i = 0; i < 4; i++) dac_m[i] = in_m[i];
      end
      2'b10: begin in_m[a] = d; dac_m[a] = d; end
      default: begin
        if (d[9]) begin
          if (pd_lock_n) shut_m = 1'b1;
        end else begin
          for (int i = 0; i < 4; i++) dac_m[i] = in_m[i];
          shut_m = 1'b0;
        end
      end
    endcase
  endtask

  // shift n bits (bits[n-1] first), check dout on both edges of every bit
  task automatic send(input logic [47:0] bits, input int n, input string tag);
    string dtag;
    dtag = dout_rise_sel ? "R11" : "R12";
    cs_n = 1'b0;
    dexp = hist[15];
    tick(8);
    chk(dtag, 32'(dout), 32'(dexp));
    for (int k = 0; k < n; k++) begin
      din = bits[n-1-k];
      tick(8);
      sclk = 1'b1;
      hist = {hist[14:0], bits[n-1-k]};
      if (dout_rise_sel) dexp = hist[15];
      tick(8);
      chk(dtag, 32'(dout), 32'(dexp));
      sclk = 1'b0;
      if (!dout_rise_sel) dexp = hist[15];
      tick(8);
      chk(dtag, 32'(dout), 32'(dexp));
    end
    tick(4);
    check_outs("R13");
    cs_n = 1'b1;
    if (n > 0 && n % 16 == 0) model_exec(bits[15:0]);
    tick(12);
    check_outs(tag);
    chk(dtag, 32'(dout), 32'(dexp));
  endtask

  function automatic logic [15:0] word(input logic [1:0] a, input logic [1:0] op,
                                       input logic [9:0] d, input logic [1:0] sb);
    return {a, op, d, sb};
  endfunction

  function automatic string op_tag(input logic [1:0] op, input logic [9:0] d);
    case (op)
      2'b00: return "R2";
      2'b01: return "R4";
      2'b10: return "R3";
      default: return d[9] ? "R6" : "R5";
    endcase
  endfunction

  initial begin
    for (int i = 0; i < 4; i++) begin in_m[i] = '0; dac_m[i] = '0; end
    tick(5);
    rst = 1'b0;
    tick(6);
    // R1: reset state
    check_outs("R1");
    chk("R1", 32'(dout), 32'd0);

    // sweep every operation and address in both data-out edge modes
    for (int m = 1; m >= 0; m--) begin
      dout_rise_sel = m[0];
      tick(4);
      for (int op = 0; op < 4; op++) begin
        for (int a = 0; a < 4; a++) begin
          logic [9:0] d;
          d = 10'((a * 337 + op * 97 + m * 511 + 41) & 10'h3ff);
          send(48'(word(2'(a), 2'(op), d, 2'b00)), 16, op_tag(2'(op), d));
        end
      end
      // data extremes on pass-through loads
      for (int a = 0; a < 4; a++) begin
        send(48'(word(2'(a), 2'b10, 10'h3ff, 2'b00)), 16, "R3");
        send(48'(word(2'(a), 2'b00, 10'h000, 2'b00)), 16, "R2");
      end
      send(48'(word(2'd1, 2'b11, 10'h000, 2'b00)), 16, "R5");
    end
    dout_rise_sel = 1'b1;
    tick(4);

    // R9: nonzero sub-bits are forwarded but not executed
    for (int s = 1; s < 4; s++)
      send(48'(word(2'(s), 2'b10, 10'(s * 200 + 7), 2'(s))), 16, "R9");
    send(48'(word(2'd0, 2'b11, 10'h200, 2'b01)), 16, "R9");

    // R10: frames whose length is not a nonzero multiple of 16
    send(48'(word(2'd2, 2'b10, 10'h155, 2'b00) >> 1), 15, "R10");
    send(48'({word(2'd3, 2'b10, 10'h2aa, 2'b00), 1'b0}), 17, "R10");
    send(48'(5'b10110), 5, "R10");
    send(48'd0, 0, "R10");
    // R10: a 32-clock frame executes its last 16 bits
    send({16'd0, word(2'd0, 2'b10, 10'h0f0, 2'b00), word(2'd1, 2'b10, 10'h30c, 2'b00)}, 32, "R10");

    // R8: wake by lockout alone restores DAC contents, not input registers
    for (int a = 0; a < 4; a++)
      send(48'(word(2'(a), 2'b10, 10'(a * 150 + 33), 2'b00)), 16, "R3");
    for (int a = 0; a < 4; a++)
      send(48'(word(2'(a), 2'b00, 10'(a * 91 + 500), 2'b00)), 16, "R2");
    send(48'(word(2'd2, 2'b11, 10'h200, 2'b00)), 16, "R6");
    chk("R6", 32'(shutdown), 32'd1);
    pd_lock_n = 1'b0;
    shut_m = 1'b0;
    tick(12);
    check_outs("R8");

    // R7: shutdown command ignored while the lockout pin is low
    send(48'(word(2'd0, 2'b11, 10'h3ff, 2'b00)), 16, "R7");
    chk("R7", 32'(shutdown), 32'd0);
    pd_lock_n = 1'b1;
    tick(12);
    check_outs("R7");

    // shutdown again, then leave it through the global-update command
    send(48'(word(2'd3, 2'b11, 10'h201, 2'b00)), 16, "R6");
    send(48'(word(2'd0, 2'b11, 10'h000, 2'b00)), 16, "R5");

    wrap_up();
  end

endmodule